// File: doc/BRIEF.md
# Three-Wire Register Programming Sequencer

This block writes a short list of configuration words into an external device that is programmed over three wires: a serial clock, an active-low enable and a serial data line. A one-cycle start pulse makes the block walk through a table of entries, beginning at entry 0. The caller chooses how many entries to send, so a session can load a chosen subset of the device's registers, for example registers 1, 3 and 6, placed in entries 0, 1 and 2. Each entry is one complete word, made of a data field followed by an address field. The word goes out most significant bit first, and the enable stays low for the whole word.

The serial clock comes from the system clock. Each half-period is `HALF_CYCLES` system cycles long, and this parameter is chosen so that the full serial period is at least 40 ns. Data changes only while the serial clock is low, so the device sees a stable bit at every rising edge. Between words the enable goes high for `GAP_HALVES` half-periods, which keeps the required minimum high time of at least 10 ns. `busy` is high from the start pulse until the last word is complete. `done` pulses for one cycle at the end.

The table is read from its port at the moment each word is loaded, so it must be held steady while `busy` is high.

Top module: `cfg_serial_loader`

## Requirements
- R1: After an asynchronous active-low reset, `serEnN` is 1 and `serClk`, `serData`, `busy` and `done` are all 0. This takes effect at once, without waiting for a clock edge.
- R2: A start pulse sampled while idle makes `busy` 1 in the next cycle. A `wordCount` value of n sends entries 0 to n in ascending order, which is n+1 words. Values above `NUM_WORDS-1` stop after the last entry.
- R3: Entry i occupies `regTable[i*WORD_W +: WORD_W]` and holds {data, address}. Exactly `WORD_W` bits are clocked in each enable-low window, MSB first.
- R4: `serData` is unchanged while `serClk` is high. `serData` is 0 whenever `serEnN` is high.
- R5: Every high phase and every low phase of `serClk` within a word lasts exactly `HALF_CYCLES` cycles. `serClk` is 0 whenever `serEnN` is high.
- R6: The first rising edge of `serClk` comes `HALF_CYCLES` cycles after `serEnN` falls. `serEnN` rises `HALF_CYCLES` cycles after the last falling edge of the word.
- R7: Between two words of one session, `serEnN` stays high for exactly `GAP_HALVES*HALF_CYCLES` cycles.
- R8: `done` is a single-cycle pulse. It is asserted in the same cycle that `busy` falls and `serEnN` rises for the last time. It comes (n+1)(2·WORD_W+1)·HALF_CYCLES + n·GAP_HALVES·HALF_CYCLES cycles after `busy` rises.
- R9: A start pulse while `busy` is high is ignored. No extra word is sent and no second `done` pulse is produced.
- R10: Reset applied in the middle of a word returns the pins to the idle levels at once. A later start sends a complete, correct session.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin a session |
| wordCount | input | IDX_W | Index of the last entry to send |
| regTable | input | NUM_WORDS*WORD_W | Entries of {data, address}, entry 0 in the low bits |
| serClk | output | 1 | Serial clock to the device |
| serEnN | output | 1 | Serial enable, active low |
| serData | output | 1 | Serial data, MSB first |
| busy | output | 1 | Session in progress |
| done | output | 1 | One-cycle pulse when the session ends |

## Verification
The main function is tried with four tables:
- **Three non-adjacent addresses with one unused entry filled with ones.** This catches word-order mistakes and an off-by-one in the count.
- **A single all-ones word.** This catches a session that wrongly inserts a gap, and tail timing when no gap follows.
- **All four entries, using alternating patterns and an all-zero word.** This separates the data/address boundary from a shift error and proves that a silent word is still framed.
- **A word whose only set bit is the data MSB.** This catches an inverted bit order.

A bench monitor rebuilds each word from the pins and times every clock phase, lead, tail and gap against the parameters. Directed runs then try a second start during a session and a reset in the middle of a word.

// File: rtl/cfg_serial_pkg.sv
package cfg_serial_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LEAD,
    PH_HIGH,
    PH_LOW,
    PH_TAIL,
    PH_GAP
  } phase_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic loadWord;   // fetch an entry into the shifter
    logic firstWord;  // the fetch is entry 0
    logic shiftBit;   // advance to the next bit
    logic clearData;  // park the data line low
    logic timerRun;   // half-period timer counts
    logic longPhase;  // timer uses the inter-word gap limit
  } dp_ctl_t;

endpackage

// File: rtl/cfg_serial_dp.sv
module cfg_serial_dp
  import cfg_serial_pkg::*;
#(
  parameter int NUM_WORDS   = 4,
  parameter int WORD_W      = 22,
  parameter int HALF_CYCLES = 2,
  parameter int GAP_HALVES  = 2,
  parameter int IDX_W       = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  dp_ctl_t                     ctl,
  input  logic [IDX_W-1:0]            wordCount,
  input  logic [NUM_WORDS*WORD_W-1:0] regTable,
  output logic                        tick,
  output logic                        lastBit,
  output logic                        lastWord,
  output logic                        serData
);

  localparam int GAP_CYC = GAP_HALVES * HALF_CYCLES;
  localparam int MAX_CYC = (GAP_CYC > HALF_CYCLES) ? GAP_CYC : HALF_CYCLES;
  localparam int TMR_W   = $clog2(MAX_CYC + 1);
  localparam int BIT_W   = $clog2(WORD_W);
  localparam logic [TMR_W-1:0] HALF_LIM = TMR_W'(HALF_CYCLES - 1);
  localparam logic [TMR_W-1:0] GAP_LIM  = TMR_W'(GAP_CYC - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(WORD_W - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_WORDS - 1);

  logic [TMR_W-1:0]  phaseTmr;
  logic [BIT_W-1:0]  bitCnt;
  logic [IDX_W-1:0]  wordIdx;
  logic [IDX_W-1:0]  nextIdx;
  logic [WORD_W-1:0] shiftReg;
  logic [WORD_W-1:0] entry [NUM_WORDS];

  // split the flat table into entries
  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_entry
    assign entry[g] = regTable[g*WORD_W +: WORD_W];
  end

  // half-period timer
  assign tick = (phaseTmr == (ctl.longPhase ? GAP_LIM : HALF_LIM));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseTmr <= '0;
    end else if (!ctl.timerRun || tick) begin
      phaseTmr <= '0;
    end else begin
      phaseTmr <= phaseTmr + TMR_W'(1);
    end
  end

  // entry selection
  assign nextIdx  = ctl.firstWord ? '0 : wordIdx + IDX_W'(1);
  assign lastWord = (wordIdx == wordCount) || (wordIdx == IDX_LAST);
  assign lastBit  = (bitCnt == BIT_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordIdx <= '0;
    end else if (ctl.loadWord) begin
      wordIdx <= nextIdx;
    end
  end

  // output shifter, MSB leaves first
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
    end else if (ctl.loadWord) begin
      shiftReg <= entry[nextIdx];
      bitCnt   <= '0;
    end else if (ctl.shiftBit) begin
      shiftReg <= {shiftReg[WORD_W-2:0], 1'b0};
      bitCnt   <= bitCnt + BIT_W'(1);
    end else if (ctl.clearData) begin
      shiftReg <= '0;
    end
  end

  assign serData = shiftReg[WORD_W-1];

  // R3: a fresh word always starts counting from its MSB
  p_load_restarts_bits_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadWord |=> (bitCnt == '0));

  // R3: the bit counter never runs past the word
  p_bit_in_word_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.shiftBit |-> (bitCnt != BIT_LAST));

endmodule

// File: rtl/cfg_serial_ctrl.sv
module cfg_serial_ctrl
  import cfg_serial_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    tick,
  input  logic    lastBit,
  input  logic    lastWord,
  output dp_ctl_t ctl,
  output logic    serClk,
  output logic    serEnN,
  output logic    busy,
  output logic    done
);

  phase_e phase, nextPhase;
  logic   finishNow;

  always_comb begin
    nextPhase     = phase;
    ctl           = '0;
    ctl.timerRun  = (phase != PH_IDLE);
    ctl.longPhase = (phase == PH_GAP);
    unique case (phase)
      PH_IDLE: if (start) begin
        nextPhase     = PH_LEAD;
        ctl.loadWord  = 1'b1;
        ctl.firstWord = 1'b1;
      end
      PH_LEAD: if (tick) nextPhase = PH_HIGH;
      PH_HIGH: if (tick) begin
        if (lastBit) begin
          nextPhase = PH_TAIL;
        end else begin
          nextPhase    = PH_LOW;
          ctl.shiftBit = 1'b1;
        end
      end
      PH_LOW:  if (tick) nextPhase = PH_HIGH;
      PH_TAIL: if (tick) begin
        ctl.clearData = 1'b1;
        nextPhase     = lastWord ? PH_IDLE : PH_GAP;
      end
      PH_GAP:  if (tick) begin
        nextPhase    = PH_LEAD;
        ctl.loadWord = 1'b1;
      end
      default: nextPhase = PH_IDLE;
    endcase
  end

  assign finishNow = (phase == PH_TAIL) && tick && lastWord;

  // pins come straight from flops loaded with the next phase
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      serClk <= 1'b0;
      serEnN <= 1'b1;
      done   <= 1'b0;
    end else begin
      phase  <= nextPhase;
      serClk <= (nextPhase == PH_HIGH);
      serEnN <= (nextPhase == PH_IDLE) || (nextPhase == PH_GAP);
      done   <= finishNow;
    end
  end

  assign busy = (phase != PH_IDLE);

  // R8: done lasts one cycle
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8: done coincides with the return to idle
  p_done_when_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R2: a session begins only on a start request
  p_busy_from_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

  // R9: a start in mid-word does not restart the word
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rstN)
    (start && (phase == PH_HIGH || phase == PH_LOW)) |=>
      (phase == PH_HIGH || phase == PH_LOW || phase == PH_TAIL));

endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
  import cfg_serial_pkg::*;
#(
  parameter int NUM_WORDS   = 4,
  parameter int DATA_W      = 18,
  parameter int ADDR_W      = 4,
  parameter int HALF_CYCLES = 2,
  parameter int GAP_HALVES  = 2,
  localparam int WORD_W     = DATA_W + ADDR_W,
  localparam int IDX_W      = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        start,
  input  logic [IDX_W-1:0]            wordCount,
  input  logic [NUM_WORDS*WORD_W-1:0] regTable,
  output logic                        serClk,
  output logic                        serEnN,
  output logic                        serData,
  output logic                        busy,
  output logic                        done
);

  dp_ctl_t ctl;
  logic    tick, lastBit, lastWord;

  cfg_serial_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .tick     (tick),
    .lastBit  (lastBit),
    .lastWord (lastWord),
    .ctl      (ctl),
    .serClk   (serClk),
    .serEnN   (serEnN),
    .busy     (busy),
    .done     (done)
  );

  cfg_serial_dp #(
    .NUM_WORDS   (NUM_WORDS),
    .WORD_W      (WORD_W),
    .HALF_CYCLES (HALF_CYCLES),
    .GAP_HALVES  (GAP_HALVES),
    .IDX_W       (IDX_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .wordCount (wordCount),
    .regTable  (regTable),
    .tick      (tick),
    .lastBit   (lastBit),
    .lastWord  (lastWord),
    .serData   (serData)
  );

  // R5: the serial clock rests low while the device is deselected
  p_clk_parked_r5: assert property (@(posedge clk) disable iff (!rstN)
    serEnN |-> !serClk);

  // R4: the data line rests low while the device is deselected
  p_data_parked_r4: assert property (@(posedge clk) disable iff (!rstN)
    serEnN |-> !serData);

  // R4: data holds through every high phase of the serial clock
  p_data_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    serClk |-> $stable(serData));

endmodule

// File: tb/cfg_serial_loader_test.sv
module cfg_serial_loader_test;

  localparam int CLK_PERIOD = 10;
  localparam int NW = 4;
  localparam int WW = 22;
  localparam int H  = 2;
  localparam int G  = 2;

  typedef struct packed {
    logic [1:0]       cnt;
    logic [NW*WW-1:0] tbl;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{cnt: 2'd2, tbl: {22'h3FFFFF, {18'h3F00F, 4'd6}, {18'h01234, 4'd3}, {18'h2A5C3, 4'd1}}},
    '{cnt: 2'd0, tbl: {22'h155555, 22'h0AAAAA, 22'h12345, {18'h3FFFF, 4'hF}}},
    '{cnt: 2'd3, tbl: {{18'h00001, 4'h8}, 22'h000000, {18'h2AAAA, 4'h5}, {18'h15555, 4'hA}}},
    '{cnt: 2'd1, tbl: {22'h3FFFFF, 22'h3FFFFF, {18'h00000, 4'h1}, {18'h20000, 4'h0}}}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [1:0] wordCount = '0;
  logic [NW*WW-1:0] regTable = '0;
  logic serClk, serEnN, serData, busy, done;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_serial_loader uut (
    .clk(clk), .rstN(rstN), .start(start), .wordCount(wordCount),
    .regTable(regTable), .serClk(serClk), .serEnN(serEnN),
    .serData(serData), .busy(busy), .done(done)
  );

  int vecCnt = 0;
  int failCnt = 0;

  // ---------------- pin monitor ----------------
  logic monClear = 1'b0;
  int cyc = 0;
  logic prevClk = 1'b0, prevEn = 1'b1, prevData = 1'b0, prevBusy = 1'b0;
  int riseT, fallT, enFallT, enRiseT, busyRiseT, doneT;
  logic firstBit;
  logic [63:0] acc;
  int bitsIn;
  int wordsCap, doneCnt;
  logic [WW-1:0] capWords [8];
  int capBits [8];
  int clkErr, edgeErr, gapErr, dataErr, doneErr;

  always @(negedge clk) begin
    cyc++;
    if (monClear) begin
      wordsCap = 0; doneCnt = 0; clkErr = 0; edgeErr = 0;
      gapErr = 0; dataErr = 0; doneErr = 0; bitsIn = 0;
    end else begin
      if (serEnN && serClk) clkErr++;
      if (serEnN && serData) dataErr++;
      if (serClk && serData !== prevData) dataErr++;
      if (prevEn && !serEnN) begin
        if (wordsCap > 0 && cyc - enRiseT != G*H) gapErr++;
        enFallT = cyc; firstBit = 1'b1; bitsIn = 0; acc = '0;
      end
      if (!prevClk && serClk) begin
        if (!serEnN) begin
          acc = {acc[62:0], serData};
          bitsIn++;
        end
        if (firstBit) begin
          if (cyc - enFallT != H) edgeErr++;
        end else if (cyc - fallT != H) clkErr++;
        firstBit = 1'b0;
        riseT = cyc;
      end
      if (prevClk && !serClk) begin
        if (cyc - riseT != H) clkErr++;
        fallT = cyc;
      end
      if (!prevEn && serEnN) begin
        if (cyc - fallT != H) edgeErr++;
        if (wordsCap < 8) begin
          capWords[wordsCap] = acc[WW-1:0];
          capBits[wordsCap]  = bitsIn;
        end
        wordsCap++;
        enRiseT = cyc;
      end
      if (!prevBusy && busy) busyRiseT = cyc;
      if (done) begin
        doneCnt++;
        doneT = cyc;
        if (busy || !(serEnN && !prevEn)) doneErr++;
      end
    end
    prevClk = serClk; prevEn = serEnN; prevData = serData; prevBusy = busy;
  end

  // ---------------- helpers ----------------
  task automatic check(input string req, input string what, input longint act, input longint exp);
    vecCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [WW-1:0] wordOf(input logic [NW*WW-1:0] t, input int i);
    return t[i*WW +: WW];
  endfunction

  task automatic clearMon();
    monClear = 1'b1;
    @(negedge clk); #1;
    monClear = 1'b0;
  endtask

  task automatic waitDone();
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk); #1;
      if (doneCnt > 0) break;
    end
  endtask

  task automatic pulseStart(input vec_t v);
    regTable  = v.tbl;
    wordCount = v.cnt;
    start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
  endtask

  task automatic runVector(input vec_t v, input int idx);
    int n;
    n = int'(v.cnt);
    clearMon();
    pulseStart(v);
    check("R2", $sformatf("v%0d busy after start", idx), busy, 1);
    waitDone();
    repeat (5) @(negedge clk);
    #1;
    check("R2", $sformatf("v%0d word count", idx), wordsCap, n + 1);
    for (int i = 0; i <= n; i++) begin
      check("R3", $sformatf("v%0d word %0d value", idx, i), capWords[i], wordOf(v.tbl, i));
      check("R3", $sformatf("v%0d word %0d bits", idx, i), capBits[i], WW);
    end
    check("R4", $sformatf("v%0d data discipline", idx), dataErr, 0);
    check("R5", $sformatf("v%0d clock phases", idx), clkErr, 0);
    check("R6", $sformatf("v%0d lead/tail", idx), edgeErr, 0);
    check("R7", $sformatf("v%0d gaps", idx), gapErr, 0);
    check("R8", $sformatf("v%0d done pulses", idx), doneCnt, 1);
    check("R8", $sformatf("v%0d done alignment", idx), doneErr, 0);
    check("R8", $sformatf("v%0d duration", idx), doneT - busyRiseT,
          (n + 1) * (2*WW + 1) * H + n * G * H);
    check("R8", $sformatf("v%0d busy low at end", idx), busy, 0);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, failCnt);
    $finish;
  end

  // ---------------- main ----------------
  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1: pins during reset
    check("R1", "reset serEnN", serEnN, 1);
    check("R1", "reset serClk", serClk, 0);
    check("R1", "reset serData", serData, 0);
    check("R1", "reset busy", busy, 0);
    check("R1", "reset done", done, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // vector table
    for (int v = 0; v < 4; v++) runVector(VECS[v], v);

    // R9: second start during a session
    clearMon();
    pulseStart(VECS[1]);
    repeat (20) @(negedge clk);
    #1;
    start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
    waitDone();
    repeat (150) @(negedge clk);
    #1;
    check("R9", "words after restart attempt", wordsCap, 1);
    check("R9", "done pulses after restart attempt", doneCnt, 1);
    check("R9", "enable idle afterwards", serEnN, 1);
    check("R9", "word value", capWords[0], wordOf(VECS[1].tbl, 0));

    // R10: reset in mid-word
    clearMon();
    pulseStart(VECS[2]);
    repeat (40) @(negedge clk);
    #2;
    rstN = 1'b0;
    #1;
    check("R10", "mid-word reset serEnN", serEnN, 1);
    check("R10", "mid-word reset serClk", serClk, 0);
    check("R10", "mid-word reset serData", serData, 0);
    check("R10", "mid-word reset busy", busy, 0);
    @(negedge clk); #1;
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    runVector(VECS[0], 10);
    check("R10", "session after reset words", wordsCap, 3);

    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, failCnt);
    $finish;
  end

endmodule